// File: doc/BRIEF.md
# Bus Slave Response Generator with Retract

This block sits on the slave side of a shared system bus, in front of a slow internal resource. Every cycle its select input is high it produces a three-bit transfer response made of a wait bit, a last bit and an error bit. While the resource reports that it is not ready, the block stretches the transfer with wait states. If the resource stays busy beyond a parameterised number of waits, the block gives up the bus with a two-cycle retract, and the master must repeat the transfer later.

The block also ends bursts at a power-of-two page boundary, so the next beat has to be issued as a fresh non-sequential transfer. It rejects writes into a read-only address region with an error. Data movement and the master's retry policy are handled elsewhere. The response is a pure function of the inputs and a small timer state, so it is valid in the same cycle as the request.

Response codes are written as {wait, last, error}. Transfer type `trans_i` uses 2'b00 for idle, 2'b01 for address-only, 2'b10 for non-sequential and 2'b11 for sequential. Only the last two are data transfers.

Top module: `resp_gen`

## Requirements
- R1: With `sel_i` low, `wait_o`, `last_o` and `error_o` are all 0 and `drive_o` is 0. With `sel_i` high, `drive_o` is 1.
- R2: A permitted data transfer with `ready_i` low, after fewer than `MAX_WAITS` waits in the current transfer, gets WAIT (100).
- R3: When `MAX_WAITS` (>0) consecutive WAIT responses have been given and `ready_i` is still low, the response is RETNEXT (111).
- R4: In the cycle after RETNEXT, with `sel_i` still high, the response is RETRACT (011) whatever `ready_i` is. The transfer is then closed and the retry starts with a fresh wait count.
- R5: A permitted, ready data transfer whose offset within the page is not the page-end offset gets DONE (000).
- R6: A permitted, ready data transfer whose address bits [log2(PAGE_BYTES)-1:0] equal PAGE_BYTES-BEAT_BYTES (0x3C by default) gets LAST (010).
- R7: A write to an address >= `RO_BASE` (0xC000 by default) gets ERROR (001) in its first cycle, regardless of `ready_i`, and takes priority over LAST. Reads there behave normally.
- R8: A selected non-data transfer (types 00 and 01) gets DONE (000) and clears the wait count.
- R9: Dropping `sel_i` clears both the wait count and a pending retract. A reselected busy transfer restarts with WAIT.
- R10: With `MAX_WAITS` = 0, a busy transfer is answered with WAIT for as long as `ready_i` stays low, and RETNEXT never appears.
- R11: The reserved codes 101 and 110 never appear while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select from the address decoder |
| trans_i | input | 2 | Transfer type: 00 idle, 01 address-only, 10 non-sequential, 11 sequential |
| addr_i | input | ADDR_W | Byte address of the current beat |
| write_i | input | 1 | 1 for a write transfer |
| ready_i | input | 1 | Internal resource can finish this cycle |
| drive_o | output | 1 | Response lines are being driven by this slave |
| wait_o | output | 1 | Response wait bit |
| last_o | output | 1 | Response last bit |
| error_o | output | 1 | Response error bit |

## Verification
The hardest states to reach are a retract that is cut short and a wait count left over from an earlier transfer. Each needs a run of at least `MAX_WAITS` busy beats followed by a change of select or transfer type at one exact cycle. The stimulus builds those runs on purpose: it deselects in the middle of a wait run and in the RETNEXT cycle, and it inserts an address-only beat between busy beats. It then checks that the next busy transfer waits the full count again. A second instance with `MAX_WAITS` = 0 runs the same stimulus, so the long busy runs also show that this variant never retracts. A seeded random phase then mixes every input.

// File: rtl/resp_pkg.sv
package resp_pkg;
  typedef enum logic [2:0] {
    RSP_DONE    = 3'b000,
    RSP_ERROR   = 3'b001,
    RSP_LAST    = 3'b010,
    RSP_RETRACT = 3'b011,
    RSP_WAIT    = 3'b100,
    RSP_RETNEXT = 3'b111
  } resp_e;

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_AONLY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ = 2'b11;

  function automatic logic is_data(input logic [1:0] tr);
    return (tr == TR_NSEQ) || (tr == TR_SEQ);
  endfunction
endpackage

// File: rtl/resp_access_chk.sv
module resp_access_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned RO_BASE = 'hC000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  output logic              deny_o
);
  localparam logic [ADDR_W-1:0] RoBase = ADDR_W'(RO_BASE);

  assign deny_o = write_i && (addr_i >= RoBase);
endmodule

// File: rtl/resp_page_chk.sv
module resp_page_chk #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned BEAT_BYTES = 4,
  localparam int unsigned PageLsb = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1
) (
  input  logic [PageLsb-1:0] ofs_i,
  output logic               page_end_o
);
  generate
    if (PAGE_BYTES <= BEAT_BYTES) begin : g_every
      // a page holds one beat: every beat closes it
      assign page_end_o = 1'b1;
    end else begin : g_cmp
      localparam logic [PageLsb-1:0] EndOfs = PageLsb'(PAGE_BYTES - BEAT_BYTES);
      assign page_end_o = (ofs_i == EndOfs);
    end
  endgenerate
endmodule

// File: rtl/resp_wait_timer.sv
module resp_wait_timer #(
  parameter int unsigned MAX_WAITS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic arm_i,
  output logic limit_o,
  output logic pend_o
);
  generate
    if (MAX_WAITS == 0) begin : g_basic
      // retract disabled: guaranteed-completion slave
      assign limit_o = 1'b0;
      assign pend_o  = 1'b0;
    end else begin : g_timer
      localparam int unsigned CntW = $clog2(MAX_WAITS + 1);
      localparam logic [CntW-1:0] Lim = CntW'(MAX_WAITS);
      logic [CntW-1:0] cnt_q;
      logic            pend_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          pend_q <= 1'b0;
        end else begin
          pend_q <= arm_i;
          if (clr_i)      cnt_q <= '0;
          else if (inc_i) cnt_q <= cnt_q + 1'b1;
        end
      end

      assign limit_o = (cnt_q == Lim);
      assign pend_o  = pend_q;
    end
  endgenerate
endmodule

// File: rtl/resp_gen.sv
module resp_gen
  import resp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned MAX_WAITS  = 3,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned BEAT_BYTES = 4,
  parameter int unsigned RO_BASE    = 'hC000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [1:0]        trans_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              ready_i,
  output logic              drive_o,
  output logic              wait_o,
  output logic              last_o,
  output logic              error_o
);
  localparam int unsigned PageLsb = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;

  logic  deny, page_end, limit, pend;
  logic  clr, inc, arm;
  resp_e code;

  resp_access_chk #(.ADDR_W(ADDR_W), .RO_BASE(RO_BASE)) u_access (
    .addr_i (addr_i),
    .write_i(write_i),
    .deny_o (deny)
  );

  resp_page_chk #(.PAGE_BYTES(PAGE_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_page (
    .ofs_i     (addr_i[PageLsb-1:0]),
    .page_end_o(page_end)
  );

  resp_wait_timer #(.MAX_WAITS(MAX_WAITS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .arm_i  (arm),
    .limit_o(limit),
    .pend_o (pend)
  );

  always_comb begin
    code = RSP_DONE;
    clr  = 1'b1;
    inc  = 1'b0;
    arm  = 1'b0;
    if (!sel_i) begin
      code = RSP_DONE;
    end else if (pend) begin
      code = RSP_RETRACT;
    end else if (!is_data(trans_i)) begin
      code = RSP_DONE;
    end else if (deny) begin
      code = RSP_ERROR;
    end else if (!ready_i) begin
      if (limit) begin
        code = RSP_RETNEXT;
        arm  = 1'b1;
      end else begin
        code = RSP_WAIT;
        inc  = 1'b1;
        clr  = 1'b0;
      end
    end else if (page_end) begin
      code = RSP_LAST;
    end else begin
      code = RSP_DONE;
    end
  end

  assign drive_o = sel_i;
  assign wait_o  = sel_i & code[2];
  assign last_o  = sel_i & code[1];
  assign error_o = sel_i & code[0];
endmodule

// File: rtl/resp_gen_chk.sv
module resp_gen_chk #(
  parameter int unsigned MAX_WAITS = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic [1:0] trans_i,
  input logic       drive_o,
  input logic       wait_o,
  input logic       last_o,
  input logic       error_o
);
  logic [2:0] rsp;
  int unsigned run_q;

  assign rsp = {wait_o, last_o, error_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     run_q <= 0;
    else if (sel_i && rsp == 3'b100) run_q <= run_q + 1;
    else                             run_q <= 0;
  end

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> (rsp == 3'b000) && !drive_o);

  // R11
  no_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> (rsp != 3'b101) && (rsp != 3'b110));

  // R4
  retract_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && $past(sel_i && rsp == 3'b111) |-> rsp == 3'b011);

  // R8
  nondata_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !trans_i[1] && !$past(sel_i && rsp == 3'b111) |-> rsp == 3'b000);

  generate
    if (MAX_WAITS > 0) begin : g_lim
      // R3
      wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && rsp == 3'b100) |-> run_q < MAX_WAITS);
    end else begin : g_basic
      // R10
      never_retract_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i |-> rsp != 3'b111);
    end
  endgenerate
endmodule

bind resp_gen resp_gen_chk #(.MAX_WAITS(MAX_WAITS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .trans_i(trans_i),
  .drive_o(drive_o),
  .wait_o (wait_o),
  .last_o (last_o),
  .error_o(error_o)
);

// File: tb/tb_resp_gen.sv
`timescale 1ns/1ps
module tb_resp_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0;
  logic [1:0]  trans = 2'b00;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rdy = 1'b1;
  logic        drv_a, w_a, l_a, e_a;
  logic        drv_b, w_b, l_b, e_b;

  int total = 0;
  int bad = 0;
  int mw_a = 0, mw_b = 0;
  bit mp_a = 0, mp_b = 0;

  always #2.5 clk = ~clk;

  resp_gen #(.MAX_WAITS(3)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .trans_i(trans), .addr_i(addr),
    .write_i(wr), .ready_i(rdy), .drive_o(drv_a), .wait_o(w_a), .last_o(l_a), .error_o(e_a));

  resp_gen #(.MAX_WAITS(0)) dut_nr (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .trans_i(trans), .addr_i(addr),
    .write_i(wr), .ready_i(rdy), .drive_o(drv_b), .wait_o(w_b), .last_o(l_b), .error_o(e_b));

  function automatic logic [2:0] model(int mx, int waits, bit pend);
    if (!sel) return 3'b000;
    if (pend) return 3'b011;
    if (!(trans == 2'b10 || trans == 2'b11)) return 3'b000;
    if (wr && addr >= 16'hC000) return 3'b001;
    if (!rdy) return (mx > 0 && waits == mx) ? 3'b111 : 3'b100;
    if (addr[5:0] == 6'h3C) return 3'b010;
    return 3'b000;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic step(bit s, logic [1:0] t, logic [15:0] a, bit w, bit r, string req);
    logic [2:0] ea, eb;
    @(negedge clk);
    sel = s; trans = t; addr = a; wr = w; rdy = r;
    #1;
    ea = model(3, mw_a, mp_a);
    eb = model(0, mw_b, mp_b);
    check(req, {drv_a, w_a, l_a, e_a}, {s, ea});
    check({req, " R10"}, {drv_b, w_b, l_b, e_b}, {s, eb});
    if (!s) begin mw_a = 0; mp_a = 0; mw_b = 0; mp_b = 0; end
    else begin
      mp_a = (ea == 3'b111); mw_a = (ea == 3'b100) ? mw_a + 1 : 0;
      mp_b = (eb == 3'b111); mw_b = (eb == 3'b100) ? mw_b + 1 : 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset", {drv_a, w_a, l_a, e_a}, 4'b0000);
    rst_ni = 1'b1;
    step(0, 2'b10, 16'h0010, 0, 0, "R1");
    step(1, 2'b10, 16'h0010, 0, 1, "R5");
    step(1, 2'b10, 16'h0020, 1, 1, "R5");
    // R2 short wait run
    step(1, 2'b10, 16'h0040, 0, 0, "R2");
    step(1, 2'b10, 16'h0040, 0, 0, "R2");
    step(1, 2'b10, 16'h0040, 0, 1, "R5");
    // R3 / R4 full retract then retry
    for (int i = 0; i < 3; i++) step(1, 2'b10, 16'h0100, 0, 0, "R2");
    step(1, 2'b10, 16'h0100, 0, 0, "R3");
    step(1, 2'b10, 16'h0100, 0, 1, "R4");
    step(1, 2'b10, 16'h0100, 0, 0, "R4");
    step(1, 2'b10, 16'h0100, 0, 1, "R4");
    // R6 page end in burst
    step(1, 2'b10, 16'h0034, 0, 1, "R6");
    step(1, 2'b11, 16'h0038, 0, 1, "R6");
    step(1, 2'b11, 16'h003C, 0, 1, "R6");
    step(1, 2'b10, 16'h007C, 1, 1, "R6");
    // R7 protected writes
    step(1, 2'b10, 16'hC000, 1, 0, "R7");
    step(1, 2'b10, 16'hC03C, 1, 1, "R7");
    step(1, 2'b10, 16'hC000, 0, 1, "R7");
    step(1, 2'b10, 16'hBFFC, 1, 1, "R7");
    // R8 non-data beat clears wait count
    step(1, 2'b01, 16'h0200, 0, 0, "R8");
    step(1, 2'b00, 16'h0200, 0, 0, "R8");
    step(1, 2'b10, 16'h0200, 0, 0, "R8");
    step(1, 2'b10, 16'h0200, 0, 0, "R8");
    step(1, 2'b01, 16'h0200, 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(1, 2'b10, 16'h0200, 0, 0, "R8");
    step(1, 2'b10, 16'h0200, 0, 0, "R8");
    step(1, 2'b10, 16'h0200, 0, 1, "R8");
    // R9 deselect mid-run and in RETNEXT cycle
    step(1, 2'b10, 16'h0300, 0, 0, "R9");
    step(1, 2'b10, 16'h0300, 0, 0, "R9");
    step(0, 2'b10, 16'h0300, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(1, 2'b10, 16'h0300, 0, 0, "R9");
    step(1, 2'b10, 16'h0300, 0, 0, "R9");
    step(0, 2'b10, 16'h0300, 0, 0, "R9");
    step(1, 2'b10, 16'h0300, 0, 0, "R9");
    step(1, 2'b10, 16'h0300, 0, 1, "R9");
    // R10 long busy run
    for (int i = 0; i < 8; i++) step(1, 2'b11, 16'h0400, 0, 0, "R10");
    step(1, 2'b11, 16'h0400, 0, 1, "R10");
    // R11 random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      a = {($urandom % 4 == 0) ? 2'b11 : 2'b00, 8'h00, 6'($urandom % 64) & 6'h3C};
      step(($urandom % 8) != 0, 2'($urandom), a, 1'($urandom), ($urandom % 10) < 4, "R11");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule